// File: doc/BRIEF.md
# Dual-Domain Clock Gear Enable Generator

This block thins one base clock into two clock-enable strobes: one paces the processor domain and one paces the peripheral domain. Each domain has its own two-bit gear code that picks a division of 1, 2, 4 or 8 base ticks per strobe. A single source bit chooses what a base tick is: every input clock cycle, or every second input clock cycle. All logic runs in the one input clock domain. Downstream logic qualifies its flops with the strobes rather than gating a clock.

Both strobes are decoded from one shared three-bit phase counter that advances on base ticks only. As a result, the slower strobe always lands on a cycle where the faster one is also high, and a transfer between the two domains always sees both sides sample together. Each domain also drives a gear indication level. This level stays high across the whole base tick that opens one of the domain's intervals.

Software writes a byte-wide configuration register over a simple write strobe and reads it back on a read bus. A newly written ratio or source choice waits until the phase counter wraps. No interval is ever cut short or stretched.

Top module: `clk_gear_gen`

## Requirements
- R1: After reset the configuration register reads 0xF0: both gear codes are 11, the source bit is 0 and the reserved bits are 0. The phase counter is zero, so on the first cycle after reset release both enables and both indications are high.
- R2: When `wr_en` is high at a clock edge, `wdata` is stored at that edge. From the next cycle `rdata` returns all eight stored bits, including the reserved bits 3:1.
- R3: Gear code 00, 01, 10 or 11 produces an enable on every 1st, 2nd, 4th or 8th base tick. The enable falls on ticks where the phase counter is a multiple of that division. The processor code is register bits 7:6 and the peripheral code is bits 5:4.
- R4: Register bit 0 selects the base tick. With 0, every input clock cycle is a tick. With 1, ticks fall on alternate cycles, set by a free-running toggle that is 0 in the first cycle after reset. The phase counter advances only on ticks, and no enable is high outside a tick.
- R5: When one domain's gear code is less than or equal to the other's, every enable of the slower domain coincides with an enable of the other domain.
- R6: Stored gear codes and the source bit take effect only at the edge where a tick occurs with the phase counter at 7. That edge returns the counter to 0. Until then the previous settings keep driving both domains.
- R7: A domain's indication is high in every input cycle whose phase counter value is a multiple of that domain's division, including the non-tick cycle of a halved tick. The domain's enable equals the indication ANDed with the tick.
- R8: Reserved bits 3:1 have no effect on either enable or indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the configuration register |
| wdata | input | 8 | Write data: [7:6] processor gear, [5:4] peripheral gear, [3:1] reserved, [0] halved source |
| rdata | output | 8 | Current configuration register contents |
| cpu_en | output | 1 | Processor-domain clock enable strobe |
| per_en | output | 1 | Peripheral-domain clock enable strobe |
| cpu_ind | output | 1 | Processor-domain gear interval indication |
| per_ind | output | 1 | Peripheral-domain gear interval indication |

## Verification
The embedded properties assume that reset is asserted before the first clock edge and released away from a rising edge. They also assume that `wdata` holds a known value in any cycle where `wr_en` is high. The bench asserts reset at time zero and drives every input only on falling edges. Across one run it sweeps all sixteen pairs of gear codes under both source settings, varying the reserved bits as well. It writes at arbitrary phases, including two writes back to back, so a new setting often arrives in the middle of an interval.

// File: rtl/gear_pkg.sv
package gear_pkg;
  localparam int GEAR_W  = 2;
  localparam int CNT_W   = (1 << GEAR_W) - 1;
  localparam int REG_W   = 8;
  localparam int CPU_LSB = 6;
  localparam int PER_LSB = 4;
  localparam int SRC_BIT = 0;
  localparam int NUM_DOM = 2;
  localparam logic [REG_W-1:0] CFG_RST = 8'hF0;

  typedef enum logic [GEAR_W-1:0] {
    GEAR_DIV1 = 2'd0,
    GEAR_DIV2 = 2'd1,
    GEAR_DIV4 = 2'd2,
    GEAR_DIV8 = 2'd3
  } gear_e;

  typedef struct packed {
    gear_e cpu;
    gear_e per;
    logic  half;
  } gear_cfg_t;

  // Low phase bits that must be zero for a strobe at gear g.
  function automatic logic [CNT_W-1:0] phase_mask(input gear_e g);
    return (CNT_W'(1) << g) - CNT_W'(1);
  endfunction

  function automatic gear_cfg_t cfg_decode(input logic [REG_W-1:0] r);
    gear_cfg_t c;
    c.cpu  = gear_e'(r[CPU_LSB +: GEAR_W]);
    c.per  = gear_e'(r[PER_LSB +: GEAR_W]);
    c.half = r[SRC_BIT];
    return c;
  endfunction
endpackage

// File: rtl/gear_cfg_reg.sv
module gear_cfg_reg
  import gear_pkg::*;
#(
  parameter int              W   = REG_W,
  parameter logic [W-1:0]    RST = CFG_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         wrap,
  output logic [W-1:0] rdata,
  output gear_cfg_t    act
);
  logic [W-1:0] cfg_q, cfg_d;
  gear_cfg_t    act_q, act_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wdata;
  end

  always_comb begin
    act_d = act_q;
    if (wrap) act_d = cfg_decode(cfg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= RST;
      act_q <= cfg_decode(RST);
    end else begin
      cfg_q <= cfg_d;
      act_q <= act_d;
    end
  end

  assign rdata = cfg_q;
  assign act   = act_q;

  // R2: a write lands on the edge that samples the strobe
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata == $past(wdata)));

  // R6: settings in force hold between wraps
  p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_q));
endmodule

// File: rtl/gear_src_div.sv
module gear_src_div (
  input  logic clk,
  input  logic rst_n,
  input  logic half,
  output logic tick
);
  logic tog_q, tog_d;

  always_comb tog_d = ~tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  assign tick = ~half | tog_q;

  // R4: halved source never ticks on two consecutive cycles
  p_half_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (half && tick) |=> (!tick || !half));
endmodule

// File: rtl/gear_phase_ctr.sv
module gear_phase_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] phase,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = '1;

  logic [W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (tick) ph_d = ph_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;
  assign wrap  = tick & (ph_q == LAST);

  // R4: phase only moves on base ticks
  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));

  // R6: a wrap always leaves the counter at zero
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (phase == '0));
endmodule

// File: rtl/gear_strobe_dec.sv
module gear_strobe_dec
  import gear_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         tick,
  input  logic [W-1:0] phase,
  input  gear_e        gear,
  output logic         en,
  output logic         ind
);
  logic [W-1:0] mask;

  always_comb begin
    mask = W'(phase_mask(gear));
    ind  = ((phase & mask) == '0);
    en   = tick & ind;
  end
endmodule

// File: rtl/clk_gear_gen.sv
module clk_gear_gen
  import gear_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             cpu_en,
  output logic             per_en,
  output logic             cpu_ind,
  output logic             per_ind
);
  gear_cfg_t          act;
  logic               tick;
  logic               wrap;
  logic [CNT_W-1:0]   phase;
  gear_e              dom_gear [NUM_DOM];
  logic [NUM_DOM-1:0] dom_en;
  logic [NUM_DOM-1:0] dom_ind;

  gear_cfg_reg #(.W(REG_W), .RST(CFG_RST)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wdata (wdata),
    .wrap  (wrap),
    .rdata (rdata),
    .act   (act)
  );

  gear_src_div u_src (
    .clk   (clk),
    .rst_n (rst_n),
    .half  (act.half),
    .tick  (tick)
  );

  gear_phase_ctr #(.W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .phase (phase),
    .wrap  (wrap)
  );

  assign dom_gear[0] = act.cpu;
  assign dom_gear[1] = act.per;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    gear_strobe_dec #(.W(CNT_W)) u_dec (
      .tick  (tick),
      .phase (phase),
      .gear  (dom_gear[d]),
      .en    (dom_en[d]),
      .ind   (dom_ind[d])
    );
  end

  assign cpu_en  = dom_en[0];
  assign per_en  = dom_en[1];
  assign cpu_ind = dom_ind[0];
  assign per_ind = dom_ind[1];

  // R5: slower domain strobes only alongside the faster one
  p_subset_per_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (per_en && (act.cpu <= act.per)) |-> cpu_en);
  p_subset_cpu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && (act.per <= act.cpu)) |-> per_en);

  // R4: no strobe outside a base tick
  p_tick_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en || per_en) |-> tick);

  // R7: strobe only inside its indication level
  p_en_in_ind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_en |-> cpu_ind) and (per_en |-> per_ind)));
endmodule

// File: tb/sim_clk_gear_gen.sv
`timescale 1ns/1ps
module sim_clk_gear_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cpu_en, per_en, cpu_ind, per_ind;

  int checks = 0;
  int failures = 0;
  bit chk_on = 1'b0;
  string cur_tag = "R3 R4 R6";

  always #4 clk = ~clk;

  clk_gear_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .cpu_en(cpu_en), .per_en(per_en), .cpu_ind(cpu_ind), .per_ind(per_ind)
  );

  // Behavioural expectation taken from the requirements
  logic [7:0] m_reg;
  int m_cpu, m_per, m_cnt;
  bit m_src, m_tog;
  bit m_tick;
  assign m_tick = !m_src || m_tog;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg <= 8'hF0; m_cpu <= 3; m_per <= 3; m_src <= 1'b0;
      m_cnt <= 0; m_tog <= 1'b0;
    end else begin
      if (wr_en) m_reg <= wdata;
      m_tog <= !m_tog;
      if (m_tick) begin
        m_cnt <= (m_cnt + 1) % 8;
        if (m_cnt == 7) begin
          m_cpu <= int'(m_reg[7:6]);
          m_per <= int'(m_reg[5:4]);
          m_src <= m_reg[0];
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      bit ec_ind, ep_ind, ec_en, ep_en;
      ec_ind = (m_cnt % (1 << m_cpu)) == 0;
      ep_ind = (m_cnt % (1 << m_per)) == 0;
      ec_en  = m_tick && ec_ind;
      ep_en  = m_tick && ep_ind;
      check(rdata == m_reg, "R2 rdata", rdata, m_reg);
      check(cpu_en == ec_en, {cur_tag, " cpu_en"}, cpu_en, ec_en);
      check(per_en == ep_en, {cur_tag, " per_en"}, per_en, ep_en);
      check(cpu_ind == ec_ind, {cur_tag, " R7 cpu_ind"}, cpu_ind, ec_ind);
      check(per_ind == ep_ind, {cur_tag, " R7 per_ind"}, per_ind, ep_ind);
      if (m_cpu <= m_per && per_en)
        check(cpu_en, "R5 per_en without cpu_en", cpu_en, 1);
      if (m_per <= m_cpu && cpu_en)
        check(per_en, "R5 cpu_en without per_en", per_en, 1);
    end
  end

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wdata = v;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'h00;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state seen right after release
    check(rdata == 8'hF0, "R1 rdata", rdata, 8'hF0);
    check(cpu_en && per_en, "R1 enables", {cpu_en, per_en}, 3);
    check(cpu_ind && per_ind, "R1 indications", {cpu_ind, per_ind}, 3);
    chk_on = 1'b1;
    repeat (20) @(negedge clk);

    cur_tag = "R3 R4 R6";
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        for (int p = 0; p < 4; p++) begin
          write_cfg({2'(c), 2'(p), 3'b000, 1'(s)});
          repeat ((c * 3 + p * 5) % 7) @(negedge clk);
          repeat (40) @(negedge clk);
        end
      end
    end

    // R8: same ratios, reserved bits varied
    cur_tag = "R8 R3";
    for (int r = 0; r < 8; r++) begin
      write_cfg({2'b01, 2'b10, 3'(r), 1'(r[0])});
      repeat (36) @(negedge clk);
    end

    // R6: back-to-back writes, only the last one reaches the domains
    cur_tag = "R6 R3";
    @(negedge clk);
    wr_en = 1'b1; wdata = 8'h00;
    @(negedge clk);
    wdata = 8'hE1;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'h00;
    repeat (60) @(negedge clk);
    write_cfg(8'h30);
    repeat (40) @(negedge clk);

    summary();
    $finish;
  end
endmodule